// File: doc/BRIEF.md
# Priority Message Insertion Link Arbiter

This block drives one transmit link word stream from three traffic classes and undoes the merge on the receive side. Data packets and control packets each raise a request. The winner receives a one-cycle grant and then owns the link until its packet closes.

A latency-critical message does not wait for the packet to finish. It is spliced into the stream on the cycle after it is offered, and the packet in flight is stalled for the two cycles the message needs. The receive half spots the marker word and diverts the message to its own output. It then hands the packet words on in order, as if the insertion had never happened.

A link word is 16 data bits plus two per-byte flags. When both flags are set the word is a control character. When both are clear the word is payload.

| Control character | Code |
|---|---|
| idle | 16'hBCBC |
| data-packet start | 16'hFBF0 |
| control-packet start | 16'hFBF1 |
| packet end | 16'hFDFD |
| inserted-message marker | 16'h5CF7 |

The transmit packet FSM has four states:
- **P_IDLE**: chooses an owner when a request is present, the link is up and nothing is being inserted (**pick**).
- **P_SOP**: sends the start character with the grant (**start**).
- **P_BODY**: forwards source words and leaves on the last one (**finish**).
- **P_EOP**: sends the end character and returns to P_IDLE (**close**).

Any insertion freezes the current state.

The insertion FSM has two states:
- **I_NONE**: sends the marker when a message arrives (**splice**).
- **I_BODY**: sends the message word and returns (**resume**).

The receive FSM has three states:
- **RX_WAIT**: leaves on a start character (**open**).
- **RX_FIRST**: no word is held yet.
- **RX_HOLD**: one word is held back so that the final word can carry a last flag (**emit**, **end**).

A separate one-bit flag marks "next word is a message".

Top module: `prio_insert_link`

## Requirements
- R1: While reset is asserted, the transmit word is the idle code with both flags set, both grants are low, and both receive outputs are invalid.
- R2: A grant is a single-cycle pulse to at most one class and only occurs while link_up is high. A request made while link_up is low is granted only after link_up rises.
- R3: The cycle after a grant pulse, the transmit word is a start character: 16'hFBF0 for the data class, 16'hFBF1 for the control class. Payload words carry flags 2'b00, and the packet closes with 16'hFDFD.
- R4: Between a start character and its end character, no other start character appears on the link.
- R5: When data and control requests are pending together at a pick, the class not granted most recently wins. After reset the data class is favoured.
- R6: A message offered with msg_vld high in cycle t appears as the marker 16'h5CF7 (flags 2'b11) on the link in cycle t+1 and as its payload word (flags 2'b00) in cycle t+2, in any packet state. msg_vld must not be high in two consecutive cycles.
- R7: In every cycle in which msg_vld is high, and in the cycle after, neither ready output is high. The stalled packet loses no word.
- R8: The receiver presents each inserted message on rx_msg_vld/rx_msg_word one cycle after its payload word is on its input.
- R9: The receiver outputs each packet's payload words in order with the correct class. Only the final word carries rx_pkt_last. Idle words and inserted messages are removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| link_up | input | 1 | link is active; gates new grants |
| dat_req | input | 1 | data class requests the link |
| dat_gnt | output | 1 | data class grant pulse |
| dat_vld | input | 1 | data source word valid |
| dat_word | input | 16 | data source word |
| dat_last | input | 1 | data source word is the last of the packet |
| dat_rdy | output | 1 | data source word taken this cycle |
| ctl_req | input | 1 | control class requests the link |
| ctl_gnt | output | 1 | control class grant pulse |
| ctl_vld | input | 1 | control source word valid |
| ctl_word | input | 16 | control source word |
| ctl_last | input | 1 | control source word is the last |
| ctl_rdy | output | 1 | control source word taken this cycle |
| msg_vld | input | 1 | latency-critical message offered |
| msg_word | input | 16 | latency-critical message payload |
| tx_word | output | 16 | transmit link word |
| tx_flag | output | 2 | transmit per-byte control flags |
| rx_word | input | 16 | receive link word |
| rx_flag | input | 2 | receive per-byte control flags |
| rx_pkt_vld | output | 1 | reconstructed packet word valid |
| rx_pkt_word | output | 16 | reconstructed packet word |
| rx_pkt_last | output | 1 | final word of the packet |
| rx_pkt_is_ctl | output | 1 | packet belongs to the control class |
| rx_msg_vld | output | 1 | extracted message valid |
| rx_msg_word | output | 16 | extracted message payload |

## Verification
The bench splices messages at the most awkward points:
- while the link is idle;
- between the pick and the start character;
- in the middle of a body;
- every other cycle over a whole control packet.

A design with a latency that varies, or that lets a stalled source advance, would show the marker late or drop or duplicate a payload word. The receive scoreboard catches both.

Simultaneous data and control requests are issued after each kind of previous grant. A fixed-priority arbiter would win the same way twice. Requests made while the link is down must stay ungranted. One-word packets exercise the held-word path, where a receiver that misplaces the last flag breaks the packet.

// File: rtl/pil_pkg.sv
package pil_pkg;
    parameter int WORD_W = 16;
    localparam int FLAG_W = WORD_W / 8;
    localparam int NCLS   = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [FLAG_W-1:0] flag_t;

    localparam flag_t FL_CHAR = '1;
    localparam flag_t FL_DATA = '0;

    localparam word_t K_IDLE = 16'hBCBC;
    localparam word_t K_SOD  = 16'hFBF0;
    localparam word_t K_SOC  = 16'hFBF1;
    localparam word_t K_EOP  = 16'hFDFD;
    localparam word_t K_MSG  = 16'h5CF7;

    typedef enum logic [1:0] {P_IDLE, P_SOP, P_BODY, P_EOP} pkt_st_t;
    typedef enum logic       {I_NONE, I_BODY}               ins_st_t;
    typedef enum logic [1:0] {RX_WAIT, RX_FIRST, RX_HOLD}   rx_st_t;
    typedef enum logic       {OWN_DAT, OWN_CTL}             owner_t;
endpackage

// File: rtl/pil_tx_arb.sv
module pil_tx_arb
    import pil_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              stall,
    input  logic [NCLS-1:0]   req,
    input  logic [NCLS-1:0]   vld,
    input  logic [NCLS-1:0]   last,
    input  word_t             src_word [NCLS],
    output logic [NCLS-1:0]   gnt,
    output logic [NCLS-1:0]   rdy,
    output word_t             pkt_word,
    output flag_t             pkt_flag
);
    pkt_st_t st, st_nx;
    owner_t  own, own_nx;
    logic    fav_ctl, fav_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= P_IDLE;
            own     <= OWN_DAT;
            fav_ctl <= 1'b0;
        end else begin
            st      <= st_nx;
            own     <= own_nx;
            fav_ctl <= fav_nx;
        end
    end

    always_comb begin
        st_nx    = st;
        own_nx   = own;
        fav_nx   = fav_ctl;
        gnt      = '0;
        rdy      = '0;
        pkt_word = K_IDLE;
        pkt_flag = FL_CHAR;
        unique case (st)
            P_IDLE: begin
                if (!stall && link_up && (|req)) begin
                    own_nx = (req[OWN_CTL] && (!req[OWN_DAT] || fav_ctl)) ? OWN_CTL : OWN_DAT;
                    st_nx  = P_SOP;
                end
            end
            P_SOP: begin
                if (!stall && link_up) begin
                    gnt[own] = 1'b1;
                    pkt_word = (own == OWN_DAT) ? K_SOD : K_SOC;
                    fav_nx   = (own == OWN_DAT);
                    st_nx    = P_BODY;
                end
            end
            P_BODY: begin
                if (!stall) begin
                    rdy[own] = 1'b1;
                    if (vld[own]) begin
                        pkt_word = src_word[own];
                        pkt_flag = FL_DATA;
                        if (last[own]) st_nx = P_EOP;
                    end
                end
            end
            P_EOP: begin
                if (!stall) begin
                    pkt_word = K_EOP;
                    st_nx    = P_IDLE;
                end
            end
        endcase
    end

    p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_gnt_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> !(|gnt));
    p_gnt_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> link_up);
    p_body_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == P_BODY && stall) |=> (st == P_BODY && $stable(own)));
endmodule

// File: rtl/pil_msg_insert.sv
module pil_msg_insert
    import pil_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  msg_vld,
    input  word_t msg_word,
    input  word_t pkt_word,
    input  flag_t pkt_flag,
    output logic  stall,
    output word_t link_word,
    output flag_t link_flag
);
    ins_st_t ins_st, ins_nx;
    word_t   held;
    word_t   nx_word;
    flag_t   nx_flag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_st    <= I_NONE;
            held      <= '0;
            link_word <= K_IDLE;
            link_flag <= FL_CHAR;
        end else begin
            ins_st    <= ins_nx;
            if (msg_vld) held <= msg_word;
            link_word <= nx_word;
            link_flag <= nx_flag;
        end
    end

    always_comb begin
        ins_nx  = ins_st;
        stall   = 1'b0;
        nx_word = pkt_word;
        nx_flag = pkt_flag;
        unique case (ins_st)
            I_NONE: begin
                if (msg_vld) begin
                    stall   = 1'b1;
                    nx_word = K_MSG;
                    nx_flag = FL_CHAR;
                    ins_nx  = I_BODY;
                end
            end
            I_BODY: begin
                stall   = 1'b1;
                nx_word = held;
                nx_flag = FL_DATA;
                ins_nx  = I_NONE;
            end
        endcase
    end

    p_marker_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_vld |=> (link_flag == FL_CHAR && link_word == K_MSG));
    p_payload_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_st == I_BODY) |=> (link_flag == FL_DATA && link_word == $past(held)));
    p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_vld |=> !msg_vld);
endmodule

// File: rtl/pil_rx_extract.sv
module pil_rx_extract
    import pil_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t rx_word,
    input  flag_t rx_flag,
    output logic  pkt_vld,
    output word_t pkt_word,
    output logic  pkt_last,
    output logic  pkt_is_ctl,
    output logic  msg_vld,
    output word_t msg_word
);
    rx_st_t st, st_nx;
    logic   msg_next, msg_next_nx;
    logic   cls, cls_nx;
    word_t  hold, hold_nx;
    logic   o_vld, o_last, o_mvld;
    word_t  o_word, o_mword;
    logic   is_char, is_data;

    assign is_char = (rx_flag == FL_CHAR);
    assign is_data = (rx_flag == FL_DATA);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= RX_WAIT;
            msg_next   <= 1'b0;
            cls        <= 1'b0;
            hold       <= '0;
            pkt_vld    <= 1'b0;
            pkt_word   <= '0;
            pkt_last   <= 1'b0;
            pkt_is_ctl <= 1'b0;
            msg_vld    <= 1'b0;
            msg_word   <= '0;
        end else begin
            st         <= st_nx;
            msg_next   <= msg_next_nx;
            cls        <= cls_nx;
            hold       <= hold_nx;
            pkt_vld    <= o_vld;
            pkt_word   <= o_word;
            pkt_last   <= o_last;
            pkt_is_ctl <= cls;
            msg_vld    <= o_mvld;
            msg_word   <= o_mword;
        end
    end

    always_comb begin
        st_nx       = st;
        msg_next_nx = 1'b0;
        cls_nx      = cls;
        hold_nx     = hold;
        o_vld       = 1'b0;
        o_word      = hold;
        o_last      = 1'b0;
        o_mvld      = 1'b0;
        o_mword     = rx_word;
        if (msg_next) begin
            o_mvld = 1'b1;
        end else if (is_char && rx_word == K_MSG) begin
            msg_next_nx = 1'b1;
        end else begin
            unique case (st)
                RX_WAIT: begin
                    if (is_char && rx_word == K_SOD) begin
                        cls_nx = 1'b0;
                        st_nx  = RX_FIRST;
                    end else if (is_char && rx_word == K_SOC) begin
                        cls_nx = 1'b1;
                        st_nx  = RX_FIRST;
                    end
                end
                RX_FIRST: begin
                    if (is_data) begin
                        hold_nx = rx_word;
                        st_nx   = RX_HOLD;
                    end else if (is_char && rx_word == K_EOP) begin
                        st_nx = RX_WAIT;
                    end
                end
                RX_HOLD: begin
                    if (is_data) begin
                        o_vld   = 1'b1;
                        hold_nx = rx_word;
                    end else if (is_char && rx_word == K_EOP) begin
                        o_vld  = 1'b1;
                        o_last = 1'b1;
                        st_nx  = RX_WAIT;
                    end
                end
                default: st_nx = RX_WAIT;
            endcase
        end
    end

    p_msg_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_next |=> (msg_vld && msg_word == $past(rx_word)));
    p_last_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_vld && pkt_last) |=> !pkt_vld);
endmodule

// File: rtl/prio_insert_link.sv
module prio_insert_link
    import pil_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              dat_req,
    output logic              dat_gnt,
    input  logic              dat_vld,
    input  logic [WORD_W-1:0] dat_word,
    input  logic              dat_last,
    output logic              dat_rdy,
    input  logic              ctl_req,
    output logic              ctl_gnt,
    input  logic              ctl_vld,
    input  logic [WORD_W-1:0] ctl_word,
    input  logic              ctl_last,
    output logic              ctl_rdy,
    input  logic              msg_vld,
    input  logic [WORD_W-1:0] msg_word,
    output logic [WORD_W-1:0] tx_word,
    output logic [FLAG_W-1:0] tx_flag,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [FLAG_W-1:0] rx_flag,
    output logic              rx_pkt_vld,
    output logic [WORD_W-1:0] rx_pkt_word,
    output logic              rx_pkt_last,
    output logic              rx_pkt_is_ctl,
    output logic              rx_msg_vld,
    output logic [WORD_W-1:0] rx_msg_word
);
    logic [NCLS-1:0] req_v, vld_v, last_v, gnt_v, rdy_v;
    word_t           src_v [NCLS];
    word_t           pkt_word;
    flag_t           pkt_flag;
    logic            stall;

    assign req_v    = {ctl_req, dat_req};
    assign vld_v    = {ctl_vld, dat_vld};
    assign last_v   = {ctl_last, dat_last};
    assign src_v[0] = dat_word;
    assign src_v[1] = ctl_word;
    assign dat_gnt  = gnt_v[0];
    assign ctl_gnt  = gnt_v[1];
    assign dat_rdy  = rdy_v[0];
    assign ctl_rdy  = rdy_v[1];

    pil_tx_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_up  (link_up),
        .stall    (stall),
        .req      (req_v),
        .vld      (vld_v),
        .last     (last_v),
        .src_word (src_v),
        .gnt      (gnt_v),
        .rdy      (rdy_v),
        .pkt_word (pkt_word),
        .pkt_flag (pkt_flag)
    );

    pil_msg_insert u_ins (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_vld   (msg_vld),
        .msg_word  (msg_word),
        .pkt_word  (pkt_word),
        .pkt_flag  (pkt_flag),
        .stall     (stall),
        .link_word (tx_word),
        .link_flag (tx_flag)
    );

    pil_rx_extract u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_word    (rx_word),
        .rx_flag    (rx_flag),
        .pkt_vld    (rx_pkt_vld),
        .pkt_word   (rx_pkt_word),
        .pkt_last   (rx_pkt_last),
        .pkt_is_ctl (rx_pkt_is_ctl),
        .msg_vld    (rx_msg_vld),
        .msg_word   (rx_msg_word)
    );

    p_stall_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_vld |-> (!dat_rdy && !ctl_rdy));
endmodule

// File: tb/prio_insert_link_tb_top.sv
module prio_insert_link_tb_top;
    import pil_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0, link_up = 1'b0;
    logic [1:0]  req = '0, vld = '0, last = '0;
    logic [15:0] src_word [2];
    logic        msg_vld = 1'b0;
    logic [15:0] msg_word = '0;
    logic        dat_gnt, ctl_gnt, dat_rdy, ctl_rdy;
    logic [1:0]  gnt, rdy;
    logic [15:0] tx_word;
    logic [1:0]  tx_flag;
    logic        rx_pkt_vld, rx_pkt_last, rx_pkt_is_ctl, rx_msg_vld;
    logic [15:0] rx_pkt_word, rx_msg_word;

    assign gnt = {ctl_gnt, dat_gnt};
    assign rdy = {ctl_rdy, dat_rdy};

    prio_insert_link dut_i (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .dat_req(req[0]), .dat_gnt(dat_gnt), .dat_vld(vld[0]), .dat_word(src_word[0]),
        .dat_last(last[0]), .dat_rdy(dat_rdy),
        .ctl_req(req[1]), .ctl_gnt(ctl_gnt), .ctl_vld(vld[1]), .ctl_word(src_word[1]),
        .ctl_last(last[1]), .ctl_rdy(ctl_rdy),
        .msg_vld(msg_vld), .msg_word(msg_word),
        .tx_word(tx_word), .tx_flag(tx_flag),
        .rx_word(tx_word), .rx_flag(tx_flag),
        .rx_pkt_vld(rx_pkt_vld), .rx_pkt_word(rx_pkt_word), .rx_pkt_last(rx_pkt_last),
        .rx_pkt_is_ctl(rx_pkt_is_ctl), .rx_msg_vld(rx_msg_vld), .rx_msg_word(rx_msg_word)
    );

    int n_chk = 0, n_bad = 0;
    logic [16:0] exp_q0 [$];
    logic [16:0] exp_q1 [$];
    logic [15:0] exp_msg [$];
    int          gnt_log [$];

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // R6: messages never offered in consecutive cycles
    task automatic send_msg(input logic [15:0] d);
        tick();
        msg_vld  = 1'b1;
        msg_word = d;
        exp_msg.push_back(d);
        tick();
        msg_vld = 1'b0;
    endtask

    task automatic run_src(input int c, input int n, input logic [15:0] base);
        int k;
        for (int i = 0; i < n; i++) begin
            logic [15:0] w;
            w = base + 16'(i);
            if (c == 0) exp_q0.push_back({i == n - 1, w});
            else        exp_q1.push_back({i == n - 1, w});
        end
        req[c] = 1'b1;
        do @(negedge clk); while (!gnt[c]);
        tick();
        req[c]      = 1'b0;
        vld[c]      = 1'b1;
        src_word[c] = base;
        last[c]     = (n == 1);
        k = 0;
        while (k < n) begin
            @(negedge clk);
            if (rdy[c]) begin
                k++;
                tick();
                if (k < n) begin
                    src_word[c] = base + 16'(k);
                    last[c]     = (k == n - 1);
                end else begin
                    vld[c]  = 1'b0;
                    last[c] = 1'b0;
                end
            end
        end
    endtask

    // link and receive monitors
    logic        p1 = 0, p2 = 0, p3 = 0, g_prev = 0, g_cls = 0, in_pkt = 0;
    logic [15:0] pd1, pd2, pd3;
    always @(negedge clk) begin
        if (rst_n) begin
            if (g_prev) chk(tx_flag == 2'b11 && tx_word == (g_cls ? K_SOC : K_SOD),
                            "R3 start char", {14'd0, tx_flag, tx_word}, {16'h3, g_cls ? K_SOC : K_SOD});
            if (tx_flag == 2'b11 && (tx_word == K_SOD || tx_word == K_SOC)) begin
                chk(!in_pkt, "R4 start inside packet", 32'(in_pkt), 0);
                in_pkt = 1'b1;
            end else if (tx_flag == 2'b11 && tx_word == K_EOP) begin
                in_pkt = 1'b0;
            end
            if (p1) chk(tx_flag == 2'b11 && tx_word == K_MSG, "R6 marker latency",
                        {14'd0, tx_flag, tx_word}, {16'h3, K_MSG});
            if (p2) chk(tx_flag == 2'b00 && tx_word == pd2, "R6 payload word",
                        {14'd0, tx_flag, tx_word}, {16'h0, pd2});
            if (p3) chk(rx_msg_vld && rx_msg_word == pd3, "R8 extract timing",
                        {15'd0, rx_msg_vld, rx_msg_word}, {16'h1, pd3});
            if (msg_vld || p1) chk(rdy == 2'b00, "R7 ready during insertion", 32'(rdy), 0);
            if (|gnt) begin
                chk(link_up && $countones(gnt) == 1, "R2 grant with link up", {link_up, gnt}, 3'b101);
                gnt_log.push_back(int'(gnt[1]));
            end
            if (rx_msg_vld) begin
                if (exp_msg.size() == 0) chk(0, "R8 unexpected message", 32'(rx_msg_word), 0);
                else begin
                    logic [15:0] e;
                    e = exp_msg.pop_front();
                    chk(rx_msg_word == e, "R8 message data", 32'(rx_msg_word), 32'(e));
                end
            end
            if (rx_pkt_vld) begin
                logic [16:0] e;
                if ((rx_pkt_is_ctl ? exp_q1.size() : exp_q0.size()) == 0)
                    chk(0, "R9 unexpected packet word", {rx_pkt_is_ctl, rx_pkt_last, rx_pkt_word}, 0);
                else begin
                    e = rx_pkt_is_ctl ? exp_q1.pop_front() : exp_q0.pop_front();
                    chk({rx_pkt_last, rx_pkt_word} == e, "R9 packet word",
                        {rx_pkt_is_ctl, rx_pkt_last, rx_pkt_word}, {rx_pkt_is_ctl, e});
                end
            end
            g_prev = |gnt; g_cls = gnt[1];
            p3 = p2; pd3 = pd2; p2 = p1; pd2 = pd1; p1 = msg_vld; pd1 = msg_word;
        end
    end

    task automatic report();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end

    initial begin
        src_word[0] = '0;
        src_word[1] = '0;
        repeat (3) tick();
        chk(tx_word == K_IDLE && tx_flag == 2'b11, "R1 idle word", {14'd0, tx_flag, tx_word}, {16'h3, K_IDLE});
        chk(gnt == 2'b00 && !rx_pkt_vld && !rx_msg_vld, "R1 quiet outputs",
            {gnt, rx_pkt_vld, rx_msg_vld}, 0);
        rst_n = 1'b1;

        // R2: request with the link down stays ungranted
        fork run_src(0, 3, 16'h1000); join_none
        repeat (8) tick();
        chk(gnt_log.size() == 0, "R2 no grant while link down", gnt_log.size(), 0);
        link_up = 1'b1;
        wait fork;
        chk(gnt_log.size() == 1 && gnt_log[0] == 0, "R2 grant after link up", gnt_log.size(), 1);

        // R6: message on an idle link
        send_msg(16'hA5A5);
        repeat (4) tick();

        // R5: data was last, so control wins the tie
        gnt_log.delete();
        fork run_src(0, 2, 16'h2000); run_src(1, 2, 16'h3000); join
        chk(gnt_log.size() == 2 && gnt_log[0] == 1 && gnt_log[1] == 0, "R5 tie after data grant",
            gnt_log[0], 1);

        // R5: control alone, then a tie goes to data
        run_src(1, 1, 16'h3100);
        gnt_log.delete();
        fork run_src(0, 1, 16'h2100); run_src(1, 1, 16'h3200); join
        chk(gnt_log.size() == 2 && gnt_log[0] == 0 && gnt_log[1] == 1, "R5 tie after control grant",
            gnt_log[0], 0);

        // R6 R7: insertion mid body, twice
        fork
            run_src(0, 8, 16'h4000);
            begin repeat (5) tick(); send_msg(16'h1234); tick(); send_msg(16'h5678); end
        join

        // R6: message offered right as a packet is picked
        fork run_src(1, 3, 16'h5000); send_msg(16'h9ABC); join

        // R7: message every other cycle over a whole packet
        fork
            run_src(1, 5, 16'h6000);
            for (int i = 0; i < 4; i++) send_msg(16'h7000 + 16'(i));
        join
        repeat (10) tick();

        chk(exp_q0.size() == 0 && exp_q1.size() == 0, "R9 all packet words delivered",
            exp_q0.size() + exp_q1.size(), 0);
        chk(exp_msg.size() == 0, "R8 all messages delivered", exp_msg.size(), 0);
        report();
    end
endmodule